// File: doc/BRIEF.md
# Dual-Width Integer Multiplier

This unit multiplies two integer operands for a datapath whose register width is either 64 bits or 32 bits, chosen per operation by a mode input. It can return the low half of the product, the high half of the signed-by-signed product, or the high half of the unsigned-by-unsigned product. A fourth operation returns a 32-bit low product widened to 64 bits, and it is legal only when the datapath runs in 64-bit mode.

An operation enters on a one-cycle valid strobe with its opcode, its mode bit and its two operands. The unit has a fixed four-cycle pipeline and takes a new operation every cycle. It returns a valid strobe with a 64-bit result. When a word-sized multiply is issued in 32-bit mode, the unit raises an illegal flag in the slot where the result would have appeared, and it gives no valid result for that operation. In 32-bit mode every result is sign-extended from bit 31 into the 64-bit output, including the high-half results.

Top module: `mulx_unit`

## Requirements
- R1: Opcode 2'b00 (low product) with `in_wide`=1 returns bits 63..0 of the product of the two 64-bit operands.
- R2: Opcode 2'b00 with `in_wide`=0 returns bits 31..0 of the product, sign-extended from bit 31 to 64 bits.
- R3: Opcode 2'b01 (signed high) with `in_wide`=1 returns bits 127..64 of the 128-bit product of the two operands taken as signed 64-bit values.
- R4: Opcode 2'b10 (unsigned high) with `in_wide`=1 returns bits 127..64 of the 128-bit unsigned product.
- R5: Opcode 2'b01 with `in_wide`=0 returns bits 63..32 of the signed product of operand bits 31..0, sign-extended from bit 31.
- R6: Opcode 2'b10 with `in_wide`=0 returns bits 63..32 of the unsigned product of operand bits 31..0, sign-extended from bit 31.
- R7: Opcode 2'b11 (word low) with `in_wide`=1 returns bits 31..0 of the product, sign-extended from bit 31.
- R8: Opcode 2'b11 with `in_wide`=0 raises `out_illegal` for exactly one cycle, in the cycle where its result would have been valid, and `out_valid` stays low in that cycle.
- R9: `out_valid` rises in the cycle after the fourth rising edge that counts from the edge that samples `in_valid`. Operations issued on consecutive cycles come out on consecutive cycles, in issue order. `out_valid` stays low in every cycle that no legal operation fills.
- R10: While `rst` is high, and in the first cycle after it falls, `out_valid` and `out_illegal` are low. The reset also clears `out_result` to zero.
- R11: In 32-bit mode, operand bits 63..32 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | Opcode: 00 low, 01 signed high, 10 unsigned high, 11 word low |
| in_wide | input | 1 | Register-width mode: 1 = 64-bit, 0 = 32-bit |
| in_a | input | 64 | Multiplicand |
| in_b | input | 64 | Multiplier |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Result, sign-extended from bit 31 in 32-bit mode |
| out_illegal | output | 1 | Pulse marking a word multiply issued in 32-bit mode |

## Verification
The bound assertions run on every cycle and check the following:
- The four-cycle timing of the valid and illegal strobes against the issue history.
- That the two strobes never rise together.
- That every 32-bit-mode result and every word result is a sign-extended 32-bit value.
- That the 64-bit low product is exact.
- That the outputs are quiet after reset.

Some things only the bench scenarios can show. These include the exact high halves at the signed corners (most-negative times most-negative, minus one times minus one) and the all-ones unsigned corner. They also include the fact that operand upper bits are ignored in 32-bit mode, and the ordering of a dense back-to-back stream mixed with idle gaps.

// File: rtl/mulx_pkg.sv
package mulx_pkg;

  typedef enum logic [1:0] {
    OP_LO      = 2'b00,
    OP_HI_SS   = 2'b01,
    OP_HI_UU   = 2'b10,
    OP_LO_WORD = 2'b11
  } mul_op_e;

  // Control that travels alongside the data through every stage.
  typedef struct packed {
    logic    vld;   // legal operation in flight
    logic    bad;   // rejected operation in flight
    mul_op_e op;
    logic    wide;  // 1: 64-bit register mode
  } mul_ctl_t;

endpackage

// File: rtl/mulx_prep.sv
// Stage 1: legality check and operand conditioning to the working width.
module mulx_prep
  import mulx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  mul_op_e         in_op,
  input  logic            in_wide,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output mul_ctl_t        ctl_q,
  output logic [XLEN-1:0] a_q,
  output logic [XLEN-1:0] b_q
);
  localparam int HALF = XLEN / 2;

  logic            legal;
  logic            sgn;
  logic [XLEN-1:0] a_c, b_c;

  always_comb begin
    legal = !((in_op == OP_LO_WORD) && !in_wide);
    sgn   = (in_op == OP_HI_SS);
    if (in_wide) begin
      a_c = in_a;
      b_c = in_b;
    end else begin
      // Narrow mode: extend the low half to the working width.
      a_c = {{HALF{sgn & in_a[HALF-1]}}, in_a[HALF-1:0]};
      b_c = {{HALF{sgn & in_b[HALF-1]}}, in_b[HALF-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else begin
      ctl_q.vld  <= in_valid & legal;
      ctl_q.bad  <= in_valid & ~legal;
      ctl_q.op   <= in_op;
      ctl_q.wide <= in_wide;
    end
    a_q <= a_c;
    b_q <= b_c;
  end

endmodule

// File: rtl/mulx_pp_array.sv
// Stage 2: 2x2 array of half-width partial products plus signed correction.
module mulx_pp_array
  import mulx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  mul_ctl_t             ctl_d,
  input  logic [XLEN-1:0]      a_d,
  input  logic [XLEN-1:0]      b_d,
  output mul_ctl_t             ctl_q,
  output logic [3:0][XLEN-1:0] pp_q,
  output logic [XLEN-1:0]      corr_q
);
  localparam int HALF = XLEN / 2;
  localparam int NSEG = 2;

  for (genvar i = 0; i < NSEG; i++) begin : g_row
    for (genvar j = 0; j < NSEG; j++) begin : g_col
      logic [XLEN-1:0] a_seg, b_seg;
      assign a_seg = {{HALF{1'b0}}, a_d[i*HALF +: HALF]};
      assign b_seg = {{HALF{1'b0}}, b_d[j*HALF +: HALF]};
      always_ff @(posedge clk) begin
        pp_q[i*NSEG+j] <= a_seg * b_seg;
      end
    end
  end

  // For a signed product at full width, the unsigned high half is too
  // large by b when a is negative and by a when b is negative.
  logic [XLEN-1:0] corr_c;
  always_comb begin
    corr_c = '0;
    if (ctl_d.op == OP_HI_SS && ctl_d.wide) begin
      corr_c = (a_d[XLEN-1] ? b_d : '0) + (b_d[XLEN-1] ? a_d : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_d;
    corr_q <= corr_c;
  end

endmodule

// File: rtl/mulx_combine.sv
// Stage 3: sum the partial products and apply the signed correction.
module mulx_combine
  import mulx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  mul_ctl_t             ctl_d,
  input  logic [3:0][XLEN-1:0] pp_d,
  input  logic [XLEN-1:0]      corr_d,
  output mul_ctl_t             ctl_q,
  output logic [XLEN-1:0]      lo_q,
  output logic [XLEN-1:0]      hi_q
);
  localparam int HALF = XLEN / 2;
  localparam int PW   = 2 * XLEN;

  logic [PW-1:0] e00, e01, e10, e11, prod;

  always_comb begin
    e00  = {{XLEN{1'b0}}, pp_d[0]};
    e01  = {{XLEN{1'b0}}, pp_d[1]} << HALF;
    e10  = {{XLEN{1'b0}}, pp_d[2]} << HALF;
    e11  = {{XLEN{1'b0}}, pp_d[3]} << XLEN;
    prod = e00 + e01 + e10 + e11;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_d;
    lo_q <= prod[XLEN-1:0];
    hi_q <= prod[PW-1:XLEN] - corr_d;
  end

endmodule

// File: rtl/mulx_select.sv
// Stage 4: pick the requested half and widen it for the register mode.
module mulx_select
  import mulx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  mul_ctl_t        ctl_d,
  input  logic [XLEN-1:0] lo_d,
  input  logic [XLEN-1:0] hi_d,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [XLEN-1:0] out_result
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] lo_nar, hi_nar, res_c;

  always_comb begin
    lo_nar = {{HALF{lo_d[HALF-1]}}, lo_d[HALF-1:0]};
    hi_nar = {{HALF{lo_d[XLEN-1]}}, lo_d[XLEN-1:HALF]};
    unique case (ctl_d.op)
      OP_LO:      res_c = ctl_d.wide ? lo_d : lo_nar;
      OP_HI_SS,
      OP_HI_UU:   res_c = ctl_d.wide ? hi_d : hi_nar;
      OP_LO_WORD: res_c = lo_nar;
      default:    res_c = lo_d;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid   <= ctl_d.vld;
      out_illegal <= ctl_d.bad;
      if (ctl_d.vld) out_result <= res_c;
    end
  end

endmodule

// File: rtl/mulx_unit.sv
module mulx_unit
  import mulx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      in_op,
  input  logic            in_wide,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_illegal
);

  mul_ctl_t             ctl1, ctl2, ctl3;
  logic [XLEN-1:0]      a1, b1, corr2, lo3, hi3;
  logic [3:0][XLEN-1:0] pp2;

  mulx_prep #(.XLEN(XLEN)) u_prep (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(mul_op_e'(in_op)),
    .in_wide(in_wide), .in_a(in_a), .in_b(in_b),
    .ctl_q(ctl1), .a_q(a1), .b_q(b1)
  );

  mulx_pp_array #(.XLEN(XLEN)) u_pp (
    .clk(clk), .rst(rst), .ctl_d(ctl1), .a_d(a1), .b_d(b1),
    .ctl_q(ctl2), .pp_q(pp2), .corr_q(corr2)
  );

  mulx_combine #(.XLEN(XLEN)) u_comb (
    .clk(clk), .rst(rst), .ctl_d(ctl2), .pp_d(pp2), .corr_d(corr2),
    .ctl_q(ctl3), .lo_q(lo3), .hi_q(hi3)
  );

  mulx_select #(.XLEN(XLEN)) u_sel (
    .clk(clk), .rst(rst), .ctl_d(ctl3), .lo_d(lo3), .hi_d(hi3),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_result(out_result)
  );

endmodule

// File: rtl/mulx_unit_chk.sv
module mulx_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [1:0]      in_op,
  input logic            in_wide,
  input logic [XLEN-1:0] in_a,
  input logic [XLEN-1:0] in_b,
  input logic            out_valid,
  input logic [XLEN-1:0] out_result,
  input logic            out_illegal
);
  localparam int HALF = XLEN / 2;
  localparam int LAT  = 4;

  logic [2:0]                cyc;
  logic [LAT-1:0]            sh_ok, sh_bad, sh_nar;
  logic [LAT-1:0][1:0]       sh_op;
  logic [LAT-1:0][XLEN-1:0]  sh_lo;
  logic                      is_bad;

  assign is_bad = in_valid && (in_op == 2'b11) && !in_wide;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc    <= '0;
      sh_ok  <= '0;
      sh_bad <= '0;
      sh_nar <= '0;
      sh_op  <= '0;
      sh_lo  <= '0;
    end else begin
      if (cyc != 3'd7) cyc <= cyc + 3'd1;
      sh_ok  <= {sh_ok[LAT-2:0],  in_valid && !is_bad};
      sh_bad <= {sh_bad[LAT-2:0], is_bad};
      sh_nar <= {sh_nar[LAT-2:0], !in_wide};
      sh_op  <= {sh_op[LAT-2:0],  in_op};
      sh_lo  <= {sh_lo[LAT-2:0],  in_a * in_b};
    end
  end

  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'(LAT)) |-> (out_valid == sh_ok[LAT-1]));

  p_illegal_slot_r8: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'(LAT)) |-> (out_illegal == sh_bad[LAT-1]));

  p_illegal_excl_r8: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> !out_valid);

  p_narrow_sext_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && sh_nar[LAT-1]) |->
      (out_result[XLEN-1:HALF] == {HALF{out_result[HALF-1]}}));

  p_word_sext_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && sh_op[LAT-1] == 2'b11) |->
      (out_result[XLEN-1:HALF] == {HALF{out_result[HALF-1]}}));

  p_low_exact_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !sh_nar[LAT-1] && sh_op[LAT-1] == 2'b00) |->
      (out_result == sh_lo[LAT-1]));

  p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_illegal));

endmodule

bind mulx_unit mulx_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
  .in_wide(in_wide), .in_a(in_a), .in_b(in_b),
  .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
);

// File: tb/mulx_unit_tb_top.sv
module mulx_unit_tb_top;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [1:0]      in_op = 2'b00;
  logic            in_wide = 1'b1;
  logic [XLEN-1:0] in_a = '0;
  logic [XLEN-1:0] in_b = '0;
  logic            out_valid;
  logic [XLEN-1:0] out_result;
  logic            out_illegal;

  always #4 clk = ~clk;  // 125 MHz

  mulx_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_wide(in_wide), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  logic        exp_v [8];
  logic        exp_i [8];
  logic [63:0] exp_r [8];
  string       exp_t [8];

  function automatic logic [63:0] sx32(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  // Returns {illegal, result}
  function automatic logic [64:0] ref_calc(logic [1:0] op, logic w,
                                           logic [63:0] a, logic [63:0] b);
    logic [127:0] ps, pu;
    logic [63:0]  ns, nu;
    ps = {{64{a[63]}}, a} * {{64{b[63]}}, b};
    pu = {64'b0, a} * {64'b0, b};
    ns = {{32{a[31]}}, a[31:0]} * {{32{b[31]}}, b[31:0]};
    nu = {32'b0, a[31:0]} * {32'b0, b[31:0]};
    case (op)
      2'b00:   return {1'b0, w ? pu[63:0]   : sx32(nu[31:0])};
      2'b01:   return {1'b0, w ? ps[127:64] : sx32(ns[63:32])};
      2'b10:   return {1'b0, w ? pu[127:64] : sx32(nu[63:32])};
      default: return w ? {1'b0, sx32(pu[31:0])} : {1'b1, 64'b0};
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] op, logic w);
    case (op)
      2'b00:   return w ? "R1" : "R2";
      2'b01:   return w ? "R3" : "R5";
      2'b10:   return w ? "R4" : "R6";
      default: return w ? "R7" : "R8";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what,
                       logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One cycle: check the slot due now, then issue (or idle).
  task automatic step(logic v, logic [1:0] op, logic w,
                      logic [63:0] a, logic [63:0] b, string ovr);
    int s, d;
    logic [64:0] r;
    @(negedge clk);
    s = cyc % 8;
    check({out_valid, out_illegal} == {exp_v[s], exp_i[s]}, exp_t[s],
          "valid/illegal", {62'b0, out_valid, out_illegal},
          {62'b0, exp_v[s], exp_i[s]});
    if (exp_v[s] && out_valid)
      check(out_result == exp_r[s], exp_t[s], "result", out_result, exp_r[s]);
    exp_v[s] = 1'b0; exp_i[s] = 1'b0; exp_t[s] = "R9";
    in_valid = v; in_op = op; in_wide = w; in_a = a; in_b = b;
    d = (cyc + 4) % 8;
    r = ref_calc(op, w, a, b);
    exp_v[d] = v && !r[64];
    exp_i[d] = v && r[64];
    exp_r[d] = r[63:0];
    exp_t[d] = !v ? "R9" : (ovr != "" ? ovr : tag_of(op, w));
    cyc++;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(1'b0, 2'b00, 1'b1, '0, '0, "");
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL R9 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 8; k++) begin
      exp_v[k] = 1'b0; exp_i[k] = 1'b0; exp_r[k] = '0; exp_t[k] = "R9";
    end
    // R10: reset state
    repeat (3) begin
      @(negedge clk);
      check(!out_valid && !out_illegal && out_result == '0, "R10", "reset outputs",
            out_result, 64'b0);
    end
    rst = 1'b0;

    // Directed corners, wide mode
    step(1, 2'b01, 1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "");
    step(1, 2'b01, 1, '1, '1, "");
    step(1, 2'b10, 1, '1, '1, "");
    step(1, 2'b01, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "");
    step(1, 2'b00, 1, '1, 64'd3, "");
    step(1, 2'b11, 1, 64'h0000_0000_FFFF_FFFF, 64'd2, "");
    step(1, 2'b10, 1, '0, '1, "");
    // Narrow corners
    step(1, 2'b01, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, "");
    step(1, 2'b10, 0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, "");
    step(1, 2'b00, 0, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_8000, "");
    // R8: word op in narrow mode, then a legal op right behind it
    step(1, 2'b11, 0, 64'd5, 64'd7, "");
    step(1, 2'b00, 1, 64'd5, 64'd7, "");
    // R11: garbage in upper halves must be ignored in narrow mode
    step(1, 2'b01, 0, 64'hDEAD_BEEF_FFFF_FFFE, 64'h1234_5678_0000_0003, "R11");
    step(1, 2'b10, 0, 64'hFFFF_FFFF_8000_0001, 64'hAAAA_AAAA_7FFF_FFFF, "R11");
    step(1, 2'b00, 0, 64'h5555_5555_0000_0010, 64'hCCCC_CCCC_0000_0020, "R11");
    idle(5);

    // Constrained random: dense stream with occasional gaps
    for (int k = 0; k < 600; k++) begin
      logic v;
      v = ($urandom % 5) != 0;
      step(v, 2'($urandom % 4), 1'($urandom % 2), rnd64(), rnd64(), "");
    end
    idle(5);

    // R9: back-to-back burst with in-order results
    for (int k = 0; k < 8; k++)
      step(1, 2'b00, 1, 64'(k + 1), 64'(k + 100), "R9");
    idle(6);

    // R10: reset while operations are in flight
    step(1, 2'b00, 1, 64'd9, 64'd9, "");
    step(1, 2'b01, 1, 64'd9, 64'd9, "");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(!out_valid && !out_illegal && out_result == '0, "R10", "mid-run reset",
          {62'b0, out_valid, out_illegal}, 64'b0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !out_illegal, "R10", "first cycle after reset",
          {62'b0, out_valid, out_illegal}, 64'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule